// File: doc/BRIEF.md
# Two-Pattern Serial Match Detector

This block watches one serial bit per clock and reports two fixed 4-bit patterns. The first pattern is 1001 and the second is 0101. Bits are taken oldest first, so the leftmost bit of each pattern is the earliest sample. A single shared Moore machine tracks partial progress toward both patterns at the same time. Each pattern drives its own registered pulse output.

Matches may overlap. The tail of one occurrence can begin the next occurrence of the same pattern or of the other pattern. Consumers use the two pulses as single-cycle event strobes. Examples are framing markers and escape detection in a serial stream.

Top module: `seqdet_top`

## Requirements
- R1: Reset is synchronous and active high. The cycle after any clock edge that samples `rst` high, both `hitY` and `hitZ` are 0, whatever the value of `serialIn`. Bits sampled before or during reset never count toward a later match.
- R2: `hitY` is 1 for exactly the one cycle after the rising edge that samples the last bit of 1001, with the oldest bit first. At all other times it is 0.
- R3: `hitZ` is 1 for exactly the one cycle after the rising edge that samples the last bit of 0101, with the oldest bit first. At all other times it is 0.
- R4: Overlapping matches of the same pattern are all reported. The stream 1001001 gives two `hitY` pulses. The stream 0101010 gives two `hitZ` pulses.
- R5: Overlap across the two patterns is kept in both directions. The stream 1001010 gives one `hitY` pulse followed by one `hitZ` pulse. The stream 0101001 gives one `hitZ` pulse followed by one `hitY` pulse.
- R6: `hitY` and `hitZ` are never 1 in the same cycle.
- R7: The outputs are Moore type. Changing `serialIn` between clock edges leaves `hitY` and `hitZ` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on the rising edge |
| rst | input | 1 | Synchronous, active-high reset to the idle state |
| serialIn | input | 1 | Serial data bit, sampled every rising edge |
| hitY | output | 1 | One-cycle pulse after the pattern 1001 completes |
| hitZ | output | 1 | One-cycle pulse after the pattern 0101 completes |

## Verification
The bench builds the block with the package default of a 4-bit state code. That width covers all nine progress states. It leaves seven unused codes, and the next-state logic sends those codes back to idle. Each cycle's outputs are compared against a model that keeps only the last four sampled bits and a count of bits since reset. The comparison covers long random streams as well as the directed overlap streams, both same-pattern and cross-pattern. A reset applied part-way through a pattern shows that the cleared history really is discarded.

// File: rtl/seqdet_pkg.sv
`timescale 1ns/1ps
package seqdet_pkg;
  localparam int STATE_W = 4;

  // Each state is named after the longest received suffix that is still
  // a prefix of either pattern; two terminal states carry the matches.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 4'd0,
    ST_0    = 4'd1,
    ST_1    = 4'd2,
    ST_01   = 4'd3,
    ST_10   = 4'd4,
    ST_010  = 4'd5,
    ST_100  = 4'd6,
    ST_HITY = 4'd7,
    ST_HITZ = 4'd8
  } detState_t;

  typedef struct packed {
    detState_t nextState;
    logic      markY;
    logic      markZ;
  } ctlStrobe_t;
endpackage

// File: rtl/seqdet_ctrl.sv
`timescale 1ns/1ps
module seqdet_ctrl
  import seqdet_pkg::*;
(
  input  detState_t  curState,
  input  logic       bitIn,
  output ctlStrobe_t strobe
);
  detState_t nxt;

  always_comb begin
    case (curState)
      ST_IDLE: nxt = bitIn ? ST_1    : ST_0;
      ST_0:    nxt = bitIn ? ST_01   : ST_0;
      ST_1:    nxt = bitIn ? ST_1    : ST_10;
      ST_01:   nxt = bitIn ? ST_1    : ST_010;
      ST_10:   nxt = bitIn ? ST_01   : ST_100;
      ST_010:  nxt = bitIn ? ST_HITZ : ST_100;
      ST_100:  nxt = bitIn ? ST_HITY : ST_0;
      ST_HITY: nxt = bitIn ? ST_1    : ST_010;
      ST_HITZ: nxt = bitIn ? ST_1    : ST_010;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.nextState = nxt;
    strobe.markY     = (nxt == ST_HITY);
    strobe.markZ     = (nxt == ST_HITZ);
  end
endmodule

// File: rtl/seqdet_dp.sv
`timescale 1ns/1ps
module seqdet_dp
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t strobe,
  output detState_t  curState,
  output logic       yOut,
  output logic       zOut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_IDLE;
      yOut     <= 1'b0;
      zOut     <= 1'b0;
    end else begin
      curState <= strobe.nextState;
      yOut     <= strobe.markY;
      zOut     <= strobe.markZ;
    end
  end

  // R6: the two match strobes never coincide
  assert_no_double_R6: assert property (@(posedge clk) disable iff (rst)
    !(yOut && zOut));

  // R2: a 1001 match cannot be followed at once by another
  assert_y_single_R2: assert property (@(posedge clk) disable iff (rst)
    yOut |=> !yOut);

  // R3: a 0101 match cannot be followed at once by another
  assert_z_single_R3: assert property (@(posedge clk) disable iff (rst)
    zOut |=> !zOut);
endmodule

// File: rtl/seqdet_top.sv
`timescale 1ns/1ps
module seqdet_top
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic hitY,
  output logic hitZ
);
  detState_t  curState;
  ctlStrobe_t strobe;

  seqdet_ctrl u_ctrl (
    .curState (curState),
    .bitIn    (serialIn),
    .strobe   (strobe)
  );

  seqdet_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState),
    .yOut     (hitY),
    .zOut     (hitZ)
  );

  // R2: both patterns end in 1, so the sampled bit before a pulse was 1
  assert_y_last_one_R2: assert property (@(posedge clk) disable iff (rst)
    hitY |-> $past(serialIn));

  // R3: same rule for the second pattern
  assert_z_last_one_R3: assert property (@(posedge clk) disable iff (rst)
    hitZ |-> $past(serialIn));
endmodule

// File: tb/sim_seqdet_top.sv
`timescale 1ns/1ps
module sim_seqdet_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic hitY, hitZ;

  int total = 0;
  int bad = 0;
  int seen = 0;
  int yCount = 0;
  int zCount = 0;
  bit [3:0] hist = 4'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seqdet_top u0 (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .hitY     (hitY),
    .hitZ     (hitZ)
  );

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkInt(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(bit b);
    logic oldY, oldZ;
    @(negedge clk);
    oldY = hitY;
    oldZ = hitZ;
    serialIn = b;
    #1;
    chk("R7 hitY held between edges", hitY, oldY);
    chk("R7 hitZ held between edges", hitZ, oldZ);
    @(posedge clk);
    #1;
    hist = {hist[2:0], b};
    seen++;
    chk("R2 hitY", hitY, (seen >= 4) && (hist == 4'b1001));
    chk("R3 hitZ", hitZ, (seen >= 4) && (hist == 4'b0101));
    chk("R6 exclusive", hitY & hitZ, 1'b0);
    if (hitY) yCount++;
    if (hitZ) zCount++;
  endtask

  task automatic doReset(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1'b1;
      serialIn = 1'($urandom);
      @(posedge clk);
      #1;
      chk("R1 hitY in reset", hitY, 1'b0);
      chk("R1 hitZ in reset", hitZ, 1'b0);
    end
    @(negedge clk);
    rst = 1'b0;
    seen = 0;
    hist = 4'b0;
  endtask

  task automatic feed(string s);
    for (int i = 0; i < s.len(); i++) drive(s[i] == "1");
  endtask

  initial begin
    int y0, z0;
    doReset(3);

    // R2 R3 basic single patterns
    y0 = yCount; feed("1001"); chkInt("R2 single 1001", yCount - y0, 1);
    doReset(1);
    z0 = zCount; feed("0101"); chkInt("R3 single 0101", zCount - z0, 1);

    // R4 same-pattern overlap
    doReset(1);
    y0 = yCount; feed("1001001"); chkInt("R4 1001001 pulses", yCount - y0, 2);
    doReset(1);
    z0 = zCount; feed("0101010"); chkInt("R4 0101010 pulses", zCount - z0, 2);

    // R5 cross-pattern overlap
    doReset(1);
    y0 = yCount; z0 = zCount; feed("1001010");
    chkInt("R5 1001010 y", yCount - y0, 1);
    chkInt("R5 1001010 z", zCount - z0, 1);
    doReset(1);
    y0 = yCount; z0 = zCount; feed("0101001");
    chkInt("R5 0101001 z", zCount - z0, 1);
    chkInt("R5 0101001 y", yCount - y0, 1);

    // R1 reset discards partial progress
    doReset(1);
    feed("100");
    doReset(1);
    y0 = yCount; feed("1");
    chk("R1 no match across reset", hitY, 1'b0);
    chkInt("R1 no pulse across reset", yCount - y0, 0);

    // Random streams, including biased ones
    for (int i = 0; i < 3000; i++) drive(1'($urandom));
    for (int i = 0; i < 1000; i++) drive(($urandom % 4) == 0);
    doReset(2);
    for (int i = 0; i < 1000; i++) drive(($urandom % 4) != 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule